// File: doc/BRIEF.md
# Paper Tape Binary Loader

This block turns a stream of 8-bit paper-tape frames into writes to an 18-bit word memory. Only frames with their top bit set carry data. Each such frame contributes its low six bits, and three of them make one word, most significant group first. The loader then interprets the words in two phases that follow each other on the same stream.

The first phase is a read-in phase. It is a list of address/data pairs and ends on a jump word. If block mode is enabled, a second phase follows. That phase is a sequence of checksummed blocks of consecutive words, and it also ends on a jump word. Each jump word sets the start address. A single-cycle done pulse marks the end of the whole load.

Every address the block produces is the 12-bit address from the tape with a field value from an input placed in the upper bits. Writes leave through a valid/ready handshake, and the frame input is stalled while a write waits. A malformed stream or a bad checksum raises a sticky flag and halts the loader.

Top module: `tape_loader`

## Requirements
- R1: A frame whose bit 7 is 0 is consumed by the handshake but contributes nothing to any word.
- R2: Bits 5..0 of three accepted frames form one 18-bit word, first frame in bits 17..12. Bit 6 of a frame is ignored.
- R3: In the read-in phase, a word with opcode bits 17..13 equal to octal 15 (word 0320000) or octal 12 (word 0240000) takes its low 12 bits as an address. The next word is written to that address.
- R4: A word with opcode octal 30 (word 0600000) ends the current phase. It sets start_addr to {field_base, low 12 bits}. If block_en is 0 after the read-in jump, or after any block-phase jump, done pulses for exactly one cycle and frame_ready stays 0 afterwards.
- R5: Any other opcode where a command word is expected sets fmt_err. The loader halts, with frame_ready held at 0.
- R6: A block starts with two header words whose opcode is octal 15, giving the start and end address. Opcode octal 12 is a format error in the block phase. A count (end minus start) of zero or less sets fmt_err.
- R7: The data words of a block are written to consecutive addresses from the start address, within field_base.
- R8: The block checksum starts at the first header word. It then adds the second header word and each data word; a carry out of bit 17 is added back in at bit 0. The word after the data must equal this checksum. If it matches, loading continues. If it differs, csum_err is set and the loader halts.
- R9: stream_end asserted before the final jump sets fmt_err, whether a word is partly assembled or a block is open. After done, stream_end is ignored.
- R10: fmt_err and csum_err stay set until reset. done is never high for two cycles in a row.
- R11: While wr_valid is high and wr_ready is low, wr_valid, wr_addr and wr_data hold steady. frame_ready is 0 whenever a write is pending.
- R12: After reset, frame_ready is 1 and wr_valid, done, fmt_err and csum_err are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_valid | input | 1 | Frame offered |
| frame_data | input | 8 | Tape frame; bit 7 marks a data frame |
| frame_ready | output | 1 | Frame accepted when high with frame_valid |
| stream_end | input | 1 | No further frames will arrive |
| block_en | input | 1 | Run the block phase after the read-in jump |
| field_base | input | 4 | Upper address bits for every address |
| wr_valid | output | 1 | Memory write pending |
| wr_ready | input | 1 | Memory takes the write |
| wr_addr | output | 16 | Write address |
| wr_data | output | 18 | Write data |
| start_addr | output | 16 | Start address from the last jump word |
| done | output | 1 | One-cycle pulse at end of load |
| fmt_err | output | 1 | Sticky format error |
| csum_err | output | 1 | Sticky checksum error |

## Verification
The bench builds the loader with its default parameters: 6-bit frame groups, three groups per word, a 16-bit address and a 12-bit local address. With these values the 4-bit field is visible in every write address, and headers near the top of the 12-bit range are reachable. Data words near all-ones force end-around carries in the checksum. A write-ready pattern that stalls every third cycle exercises the frame stall during a pending write.

// File: rtl/tape_ld_pkg.sv
package tape_ld_pkg;
  localparam int OPC_W = 5;
  localparam logic [OPC_W-1:0] OPC_DEPOSIT     = 5'o15;
  localparam logic [OPC_W-1:0] OPC_DEPOSIT_ALT = 5'o12;
  localparam logic [OPC_W-1:0] OPC_JUMP        = 5'o30;

  typedef enum logic [2:0] {
    ST_RI_CMD,
    ST_RI_DATA,
    ST_BK_HDR1,
    ST_BK_HDR2,
    ST_BK_DATA,
    ST_BK_SUM,
    ST_DONE,
    ST_FAIL
  } ld_state_e;
endpackage

// File: rtl/tape_frame_packer.sv
module tape_frame_packer #(
  parameter int CHUNK_W = 6,
  parameter int CHUNKS  = 3
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        take,
  input  logic [CHUNK_W+1:0]          frame,
  output logic                        word_valid,
  output logic [CHUNK_W*CHUNKS-1:0]   word,
  output logic                        partial
);
  localparam int FRAME_W = CHUNK_W + 2;
  localparam int CNT_W   = $clog2(CHUNKS);
  localparam int ACC_W   = (CHUNKS - 1) * CHUNK_W;

  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic [ACC_W-1:0] acc_q, acc_n;
  logic             mark, last;
  logic [CHUNK_W-1:0] chunk;

  assign mark  = frame[FRAME_W-1];
  assign chunk = frame[CHUNK_W-1:0];
  assign last  = (cnt_q == CNT_W'(CHUNKS - 1));

  assign word       = {acc_q, chunk};
  assign word_valid = take && mark && last;
  assign partial    = (cnt_q != '0);

  generate
    if (CHUNKS > 2) begin : g_shift
      always_comb begin
        acc_n = acc_q;
        if (take && mark) acc_n = {acc_q[ACC_W-CHUNK_W-1:0], chunk};
      end
    end else begin : g_single
      always_comb begin
        acc_n = acc_q;
        if (take && mark) acc_n = chunk;
      end
    end
  endgenerate

  always_comb begin
    cnt_n = cnt_q;
    if (take && mark) cnt_n = last ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      acc_q <= '0;
    end else begin
      cnt_q <= cnt_n;
      acc_q <= acc_n;
    end
  end

  // R2
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < CNT_W'(CHUNKS));
endmodule

// File: rtl/tape_ld_eac_add.sv
module tape_ld_eac_add #(
  parameter int W = 18
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y
);
  logic [W:0] raw;
  assign raw = {1'b0, a} + {1'b0, b};
  assign y   = raw[W-1:0] + {{(W-1){1'b0}}, raw[W]};
endmodule

// File: rtl/tape_ld_seq.sv
module tape_ld_seq
  import tape_ld_pkg::*;
#(
  parameter int WORD_W   = 18,
  parameter int ADDR_W   = 16,
  parameter int LOCAL_AW = 12
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         word_valid,
  input  logic [WORD_W-1:0]            word,
  input  logic                         partial,
  input  logic                         stream_end,
  input  logic                         block_en,
  input  logic [ADDR_W-LOCAL_AW-1:0]   field_base,
  input  logic                         wr_ready,
  output logic                         wr_valid,
  output logic [ADDR_W-1:0]            wr_addr,
  output logic [WORD_W-1:0]            wr_data,
  output logic [ADDR_W-1:0]            start_addr,
  output logic                         done,
  output logic                         fmt_err,
  output logic                         csum_err,
  output logic                         busy
);
  ld_state_e state_q, state_n;
  logic [LOCAL_AW-1:0] cur_q, cur_n, remain_q, remain_n;
  logic [WORD_W-1:0]   csum_q, csum_n, csum_sum, wr_data_n;
  logic [ADDR_W-1:0]   wr_addr_n, start_n;
  logic                wr_valid_n, done_n, fmt_n, csum_err_n;
  logic [OPC_W-1:0]    opc;
  logic [LOCAL_AW-1:0] low;
  logic [LOCAL_AW:0]   span;
  logic                open_end;

  assign opc  = word[WORD_W-1 -: OPC_W];
  assign low  = word[LOCAL_AW-1:0];
  assign span = {1'b0, low} - {1'b0, cur_q};
  assign open_end = (state_q != ST_DONE) && (state_q != ST_FAIL);

  tape_ld_eac_add #(.W(WORD_W)) u_add (.a(csum_q), .b(word), .y(csum_sum));

  always_comb begin
    state_n    = state_q;
    cur_n      = cur_q;
    remain_n   = remain_q;
    csum_n     = csum_q;
    wr_valid_n = wr_valid && !wr_ready;
    wr_addr_n  = wr_addr;
    wr_data_n  = wr_data;
    start_n    = start_addr;
    done_n     = 1'b0;
    fmt_n      = fmt_err;
    csum_err_n = csum_err;
    if (word_valid) begin
      unique case (state_q)
        ST_RI_CMD, ST_BK_HDR1: begin
          if (opc == OPC_JUMP) begin
            start_n = {field_base, low};
            if (state_q == ST_RI_CMD && block_en) state_n = ST_BK_HDR1;
            else begin
              state_n = ST_DONE;
              done_n  = 1'b1;
            end
          end else if (opc == OPC_DEPOSIT ||
                       (state_q == ST_RI_CMD && opc == OPC_DEPOSIT_ALT)) begin
            cur_n   = low;
            csum_n  = word;
            state_n = (state_q == ST_RI_CMD) ? ST_RI_DATA : ST_BK_HDR2;
          end else begin
            fmt_n   = 1'b1;
            state_n = ST_FAIL;
          end
        end
        ST_RI_DATA: begin
          wr_valid_n = 1'b1;
          wr_addr_n  = {field_base, cur_q};
          wr_data_n  = word;
          state_n    = ST_RI_CMD;
        end
        ST_BK_HDR2: begin
          if (opc != OPC_DEPOSIT || span[LOCAL_AW] || span == '0) begin
            fmt_n   = 1'b1;
            state_n = ST_FAIL;
          end else begin
            csum_n   = csum_sum;
            remain_n = span[LOCAL_AW-1:0];
            state_n  = ST_BK_DATA;
          end
        end
        ST_BK_DATA: begin
          wr_valid_n = 1'b1;
          wr_addr_n  = {field_base, cur_q};
          wr_data_n  = word;
          csum_n     = csum_sum;
          cur_n      = cur_q + 1'b1;
          remain_n   = remain_q - 1'b1;
          if (remain_q == LOCAL_AW'(1)) state_n = ST_BK_SUM;
        end
        ST_BK_SUM: begin
          if (word != csum_q) begin
            csum_err_n = 1'b1;
            state_n    = ST_FAIL;
          end else state_n = ST_BK_HDR1;
        end
        default: ;
      endcase
    end else if (stream_end && open_end) begin
      fmt_n   = 1'b1;
      state_n = ST_FAIL;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_RI_CMD;
      cur_q      <= '0;
      remain_q   <= '0;
      csum_q     <= '0;
      wr_valid   <= 1'b0;
      wr_addr    <= '0;
      wr_data    <= '0;
      start_addr <= '0;
      done       <= 1'b0;
      fmt_err    <= 1'b0;
      csum_err   <= 1'b0;
    end else begin
      state_q    <= state_n;
      cur_q      <= cur_n;
      remain_q   <= remain_n;
      csum_q     <= csum_n;
      wr_valid   <= wr_valid_n;
      wr_addr    <= wr_addr_n;
      wr_data    <= wr_data_n;
      start_addr <= start_n;
      done       <= done_n;
      fmt_err    <= fmt_n;
      csum_err   <= csum_err_n;
    end
  end

  assign busy = open_end && !wr_valid;

  // R11
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)));
  // R10
  fmt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fmt_err |=> fmt_err);
  // R10
  csum_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    csum_err |=> csum_err);
  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R5
  halt_on_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fmt_err || csum_err) |-> !busy);
  // R8
  single_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(fmt_err && csum_err));
endmodule

// File: rtl/tape_loader.sv
module tape_loader #(
  parameter int CHUNK_W  = 6,
  parameter int CHUNKS   = 3,
  parameter int ADDR_W   = 16,
  parameter int LOCAL_AW = 12
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         frame_valid,
  input  logic [CHUNK_W+1:0]           frame_data,
  output logic                         frame_ready,
  input  logic                         stream_end,
  input  logic                         block_en,
  input  logic [ADDR_W-LOCAL_AW-1:0]   field_base,
  output logic                         wr_valid,
  input  logic                         wr_ready,
  output logic [ADDR_W-1:0]            wr_addr,
  output logic [CHUNK_W*CHUNKS-1:0]    wr_data,
  output logic [ADDR_W-1:0]            start_addr,
  output logic                         done,
  output logic                         fmt_err,
  output logic                         csum_err
);
  localparam int WORD_W = CHUNK_W * CHUNKS;

  logic              rst_meta_q, rst_sync_n;
  logic              take, word_valid, partial, busy;
  logic [WORD_W-1:0] word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  assign frame_ready = busy && rst_sync_n;
  assign take        = frame_valid && frame_ready;

  tape_frame_packer #(.CHUNK_W(CHUNK_W), .CHUNKS(CHUNKS)) u_packer (
    .clk(clk), .rst_n(rst_sync_n), .take(take), .frame(frame_data),
    .word_valid(word_valid), .word(word), .partial(partial)
  );

  tape_ld_seq #(.WORD_W(WORD_W), .ADDR_W(ADDR_W), .LOCAL_AW(LOCAL_AW)) u_seq (
    .clk(clk), .rst_n(rst_sync_n), .word_valid(word_valid), .word(word),
    .partial(partial), .stream_end(stream_end), .block_en(block_en),
    .field_base(field_base), .wr_ready(wr_ready), .wr_valid(wr_valid),
    .wr_addr(wr_addr), .wr_data(wr_data), .start_addr(start_addr),
    .done(done), .fmt_err(fmt_err), .csum_err(csum_err), .busy(busy)
  );

  // R11
  stall_on_write_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    wr_valid |-> !frame_ready);
  // R9
  end_mid_word_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (stream_end && partial && !word_valid && !done && !fmt_err && !csum_err
     && frame_ready) |=> fmt_err);
endmodule

// File: tb/tape_loader_bench.sv
module tape_loader_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        frame_valid;
  logic [7:0]  frame_data;
  logic        frame_ready;
  logic        stream_end;
  logic        block_en;
  logic [3:0]  field_base;
  logic        wr_valid;
  logic        wr_ready;
  logic [15:0] wr_addr;
  logic [17:0] wr_data;
  logic [15:0] start_addr;
  logic        done;
  logic        fmt_err;
  logic        csum_err;

  int checks = 0;
  int failures = 0;
  int done_cnt = 0;
  logic [15:0] seen_start;
  logic [33:0] exp_q[$];
  int rdy_cnt = 0;
  bit rdy_stall = 1'b0;

  always #10 clk = ~clk;

  tape_loader u_tape_loader (
    .clk(clk), .rst_n(rst_n), .frame_valid(frame_valid), .frame_data(frame_data),
    .frame_ready(frame_ready), .stream_end(stream_end), .block_en(block_en),
    .field_base(field_base), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .start_addr(start_addr), .done(done),
    .fmt_err(fmt_err), .csum_err(csum_err)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [17:0] eac(input logic [17:0] a, input logic [17:0] b);
    logic [18:0] s;
    s = {1'b0, a} + {1'b0, b};
    if (s[18]) s = {1'b0, s[17:0]} + 19'd1;
    return s[17:0];
  endfunction

  always @(posedge clk) begin
    #2;
    rdy_cnt++;
    wr_ready <= rdy_stall ? (rdy_cnt % 3 != 0) : 1'b1;
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (wr_valid && wr_ready) begin
        if (exp_q.size() == 0) check(1'b0, "R3 unexpected write", {wr_addr, wr_data}, 0);
        else begin
          logic [33:0] e;
          e = exp_q.pop_front();
          check({wr_addr, wr_data} == e, "R3/R7 write", {wr_addr, wr_data}, e);
        end
      end
      if (done) begin
        done_cnt++;
        seen_start = start_addr;
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    frame_valid = 1'b0;
    frame_data = 8'h00;
    stream_end = 1'b0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    exp_q.delete();
    done_cnt = 0;
    seen_start = '0;
    idle(4);
  endtask

  task automatic send_frame(input logic [7:0] b);
    @(posedge clk);
    #2;
    frame_valid = 1'b1;
    frame_data = b;
    do @(negedge clk); while (!frame_ready);
    @(posedge clk);
    #2 frame_valid = 1'b0;
  endtask

  task automatic send_word(input logic [17:0] w, input bit junk);
    for (int k = 0; k < 3; k++) begin
      if (junk) send_frame(8'h7F);
      send_frame({2'b11, w[17-6*k -: 6]});
    end
  endtask

  task automatic expect_wr(input logic [3:0] f, input logic [11:0] a, input logic [17:0] d);
    exp_q.push_back({f, a, d});
  endtask

  task automatic send_block(input logic [3:0] f, input logic [11:0] s,
                            input logic [17:0] d0, input logic [17:0] d1,
                            input logic [17:0] d2, input int n, input bit bad);
    logic [17:0] h1, h2, cs;
    logic [17:0] dv[3];
    dv[0] = d0; dv[1] = d1; dv[2] = d2;
    h1 = 18'o320000 | {6'd0, s};
    h2 = 18'o320000 | {6'd0, s + 12'(n)};
    cs = eac(h1, h2);
    send_word(h1, 1'b0);
    send_word(h2, 1'b0);
    for (int i = 0; i < n; i++) begin
      expect_wr(f, s + 12'(i), dv[i]);
      cs = eac(cs, dv[i]);
      send_word(dv[i], 1'b0);
    end
    send_word(bad ? cs + 18'd1 : cs, 1'b0);
  endtask

  initial begin
    #(200000 * 20);
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    wr_ready = 1'b1;
    block_en = 1'b0;
    field_base = 4'h0;
    do_reset();

    // R12 reset state
    check(frame_ready == 1'b1, "R12 frame_ready", frame_ready, 1);
    check({wr_valid, done, fmt_err, csum_err} == 4'b0, "R12 outputs low",
          {wr_valid, done, fmt_err, csum_err}, 0);

    // R1 R2 R3 R4 R11: read-in only, junk frames, stalling memory
    rdy_stall = 1'b1;
    field_base = 4'h3;
    expect_wr(4'h3, 12'o0100, 18'o123456);
    expect_wr(4'h3, 12'o0777, 18'o777777);
    send_word(18'o320100, 1'b1);
    send_word(18'o123456, 1'b1);
    send_word(18'o240777, 1'b0);
    send_word(18'o777777, 1'b0);
    send_word(18'o600200, 1'b1);
    idle(8);
    check(exp_q.size() == 0, "R3 all writes seen", exp_q.size(), 0);
    check(done_cnt == 1, "R4 done count", done_cnt, 1);
    check(seen_start == {4'h3, 12'o0200}, "R4 start address", seen_start, {4'h3, 12'o0200});
    check(frame_ready == 1'b0, "R4 halted after done", frame_ready, 0);
    stream_end = 1'b1;
    idle(4);
    check(fmt_err == 1'b0, "R9 stream_end ignored after done", fmt_err, 0);

    // R6 R7 R8: block phase with carries
    do_reset();
    block_en = 1'b1;
    field_base = 4'h5;
    expect_wr(4'h5, 12'o0001, 18'o000007);
    send_word(18'o320001, 1'b0);
    send_word(18'o000007, 1'b0);
    send_word(18'o600010, 1'b0);
    send_block(4'h5, 12'o0010, 18'o777770, 18'o400001, 18'o123456, 3, 1'b0);
    send_block(4'h5, 12'o7776, 18'o000042, 18'o0, 18'o0, 1, 1'b0);
    send_word(18'o600050, 1'b0);
    idle(8);
    check(exp_q.size() == 0, "R7 block writes seen", exp_q.size(), 0);
    check(done_cnt == 1, "R4 single done after block phase", done_cnt, 1);
    check(seen_start == {4'h5, 12'o0050}, "R4 block start", seen_start, {4'h5, 12'o0050});
    check({fmt_err, csum_err} == 2'b00, "R8 good checksum", {fmt_err, csum_err}, 0);

    // R8 R10: bad checksum
    do_reset();
    field_base = 4'h0;
    send_word(18'o600000, 1'b0);
    send_block(4'h0, 12'o0100, 18'o000001, 18'o000002, 18'o0, 2, 1'b1);
    idle(6);
    check(csum_err == 1'b1, "R8 checksum error", csum_err, 1);
    check(fmt_err == 1'b0, "R8 no format error", fmt_err, 0);
    idle(20);
    check(csum_err == 1'b1, "R10 csum sticky", csum_err, 1);
    check(frame_ready == 1'b0 && done_cnt == 0, "R8 halted no done",
          {frame_ready, 8'(done_cnt)}, 0);
    check(exp_q.size() == 0, "R7 data written before checksum", exp_q.size(), 0);

    // R5 bad opcode
    do_reset();
    send_word(18'o100000, 1'b0);
    idle(3);
    check(fmt_err == 1'b1, "R5 bad opcode", fmt_err, 1);
    check(frame_ready == 1'b0, "R5 halted", frame_ready, 0);
    idle(10);
    check(fmt_err == 1'b1, "R10 fmt sticky", fmt_err, 1);

    // R6 zero count
    do_reset();
    send_word(18'o600000, 1'b0);
    send_word(18'o320020, 1'b0);
    send_word(18'o320020, 1'b0);
    idle(3);
    check(fmt_err == 1'b1, "R6 zero count", fmt_err, 1);

    // R6 negative count
    do_reset();
    send_word(18'o600000, 1'b0);
    send_word(18'o320030, 1'b0);
    send_word(18'o320020, 1'b0);
    idle(3);
    check(fmt_err == 1'b1, "R6 negative count", fmt_err, 1);

    // R6 alternate tag rejected in block phase
    do_reset();
    send_word(18'o600000, 1'b0);
    send_word(18'o240020, 1'b0);
    idle(3);
    check(fmt_err == 1'b1, "R6 alt tag in block phase", fmt_err, 1);

    // R9 end mid-word
    do_reset();
    block_en = 1'b0;
    send_frame(8'hC1);
    stream_end = 1'b1;
    idle(3);
    check(fmt_err == 1'b1, "R9 end mid-word", fmt_err, 1);

    // R9 end mid-block
    do_reset();
    block_en = 1'b1;
    send_word(18'o600000, 1'b0);
    send_word(18'o320000, 1'b0);
    stream_end = 1'b1;
    idle(3);
    check(fmt_err == 1'b1 && done_cnt == 0, "R9 end mid-block",
          {fmt_err, 8'(done_cnt)}, 9'h100);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule